// File: doc/BRIEF.md
# Iterative Integer Divide and Modulo Unit

This block computes quotients and remainders of integer operands, one quotient bit per clock. It handles signed and unsigned operands, full-width (XLEN) and half-width (word) operands, and an extended divide. In the extended divide the first operand is placed in the upper half of a double-width dividend whose lower half is zero, and the quotient must fit the operand width. A caller pulses `start` with the operands and an operation select. It waits for the single-cycle `done` pulse, then reads the result, the overflow indication and the flag updates.

Overflow cases that can be decided from the operands alone finish one cycle after start, with a zero result:
- divide by zero;
- most-negative divided by minus one;
- an extended divide whose dividend magnitude is not below the divisor magnitude.

All other operations convert the operands to magnitudes and run a restoring divider for K iterations, where K is XLEN, or XLEN/2 in word mode. A final cycle then restores the signs and applies the fit check of the signed extended divide. Modulo operations never request a flag update. Divide operations can request an overflow/summary-overflow update, a condition-field update, or both.

Top module: `idiv_unit`

## Requirements
- R1: With `sgn`=0, `kind`=0 (divide) gives floor(A/B) and `kind`=2 (modulo) gives A mod B on K-bit operands. In word mode (`word`=1, K=XLEN/2) only the low K bits of each operand are used, and the upper half of the result is zero.
- R2: With `sgn`=1, a divide truncates toward zero and a modulo returns a remainder carrying the sign of the dividend. In word mode a signed modulo is sign-extended to XLEN bits, while a signed divide has a zero upper half. `kind`=3 behaves as `kind`=0.
- R3: A zero divisor (its low K bits all zero) in any form gives `ov`=1 and `result`=0.
- R4: A signed divide or modulo of the most negative K-bit value by all-ones K bits gives `ov`=1 and `result`=0.
- R5: `kind`=1 with `sgn`=0 divides A·2^K by B. It succeeds only when A <u B; otherwise it gives `ov`=1 and `result`=0.
- R6: `kind`=1 with `sgn`=1 divides A·2^K by sign-extended B. It gives `ov`=1 and `result`=0 whenever the true quotient lies outside the signed K-bit range. A valid quotient is returned in the low K bits, with a zero upper half in word mode.
- R7: When start is sampled, the overflows that R3, R4 and the extended case |A|>=|B| decide from the operands raise `done` in the next cycle. Every other operation raises `done` K+2 cycles after the start cycle. `done` lasts one cycle.
- R8: `flags_we` = `oe` and not modulo. When it is 1, `ov32` equals `ov` and `so_out` = `so_in` OR `ov`. When it is 0, `so_out` = `so_in`.
- R9: `cr0_we` = `rc` and not modulo. `cr0` is {negative, positive, zero, `so_out`}, from bit 3 down to bit 0, for the XLEN-bit result taken as signed.
- R10: `busy` is high from the cycle after an accepted start up to the cycle before `done`. A start while busy is ignored and produces neither a second `done` nor a different result.
- R11: After reset `busy`, `done` and `result` are 0. The outputs hold their values from `done` until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| kind | input | 2 | 0 divide, 1 extended divide, 2 modulo, 3 divide |
| sgn | input | 1 | Signed operands |
| word | input | 1 | Use low half of operands |
| oe | input | 1 | Request overflow flag update |
| rc | input | 1 | Request condition field update |
| so_in | input | 1 | Current summary-overflow bit |
| opa | input | XLEN | Dividend operand |
| opb | input | XLEN | Divisor operand |
| busy | output | 1 | Iterating |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Quotient or remainder, zero on overflow |
| ov | output | 1 | Overflow indication |
| ov32 | output | 1 | Word overflow flag value |
| so_out | output | 1 | Updated summary-overflow bit |
| flags_we | output | 1 | ov/ov32/so_out are to be written |
| cr0 | output | 4 | Condition field {lt, gt, eq, so} |
| cr0_we | output | 1 | cr0 is to be written |

## Verification
The bench uses an 8-bit instance. In word mode it sweeps every pair of 4-bit operands through all six operation forms, with varying upper bits to show that those bits are ignored. In full-width mode it takes a strided grid of operand pairs plus a cross of the edge values (0, 1, ±1, most negative, most positive). The full sweep separates truncation direction and remainder sign from an off-by-one in the restoring step. The edge-value cross separates the early overflow exits from the late signed-extended fit check, and the per-operation latency shows which path was taken. Varied oe/rc/so_in bits check the flag and condition outputs, and a start issued during an operation checks that it is ignored.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
   typedef enum logic [1:0] {
      KIND_DIV = 2'b00,
      KIND_EXT = 2'b01,
      KIND_MOD = 2'b10,
      KIND_ALT = 2'b11
   } div_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } div_state_e;
endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: width selection, magnitudes, early overflow detection
module idiv_prep
   import idiv_pkg::*;
#(
   parameter int N  = 64,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  a,
   input  logic [N-1:0]  b,
   input  logic [1:0]    kind,
   input  logic          sgn,
   input  logic          word,
   output logic [N-1:0]  dvs_mag,
   output logic [N-1:0]  rem_init,
   output logic [N-1:0]  low_init,
   output logic          neg_q,
   output logic          neg_r,
   output logic          early_ov,
   output logic [CW-1:0] iters
);
   localparam int W = N / 2;
   localparam logic [N-1:0] ONE_N = N'(1);
   localparam logic [CW-1:0] IT_D = CW'(N);
   localparam logic [CW-1:0] IT_W = CW'(W);

   logic [N-1:0] a_k, b_k, a_mag;
   logic         sa, sb, min_a, neg1_b, is_ext;

   always_comb begin
      if (word) begin
         a_k = sgn ? {{W{a[W-1]}}, a[W-1:0]} : {{W{1'b0}}, a[W-1:0]};
         b_k = sgn ? {{W{b[W-1]}}, b[W-1:0]} : {{W{1'b0}}, b[W-1:0]};
         sa = sgn & a[W-1];
         sb = sgn & b[W-1];
         min_a = sgn & (a[W-1:0] == {1'b1, {(W-1){1'b0}}});
         neg1_b = sgn & (&b[W-1:0]);
      end else begin
         a_k = a;
         b_k = b;
         sa = sgn & a[N-1];
         sb = sgn & b[N-1];
         min_a = sgn & (a == {1'b1, {(N-1){1'b0}}});
         neg1_b = sgn & (&b);
      end
      a_mag   = sa ? (~a_k + ONE_N) : a_k;
      dvs_mag = sb ? (~b_k + ONE_N) : b_k;
      is_ext  = (div_kind_e'(kind) == KIND_EXT);
      early_ov = is_ext ? (a_mag >= dvs_mag)
                        : ((dvs_mag == '0) | (min_a & neg1_b));
      rem_init = is_ext ? a_mag : '0;
      low_init = is_ext ? '0 : (word ? (a_mag << W) : a_mag);
      neg_q = sa ^ sb;
      neg_r = sa;
      iters = word ? IT_W : IT_D;
   end
endmodule

// File: rtl/idiv_core.sv
// Restoring radix-2 magnitude divider, one quotient bit per cycle
module idiv_core #(
   parameter int N  = 64,
   parameter int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [N-1:0]  rem_init,
   input  logic [N-1:0]  low_init,
   input  logic [N-1:0]  dvs_init,
   input  logic [CW-1:0] iters,
   output logic [N-1:0]  quo,
   output logic [N-1:0]  rem,
   output logic          last
);
   localparam logic [CW-1:0] ONE_C = CW'(1);

   logic [N-1:0]  low, dvs;
   logic [CW-1:0] cnt;
   logic [N:0]    sh, sub;
   logic          ge;

   always_comb begin
      sh  = {rem, low[N-1]};
      sub = sh - {1'b0, dvs};
      ge  = (sh >= {1'b0, dvs});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0;
         low <= '0;
         quo <= '0;
         dvs <= '0;
         cnt <= '0;
      end else if (load) begin
         rem <= rem_init;
         low <= low_init;
         quo <= '0;
         dvs <= dvs_init;
         cnt <= iters;
      end else if (cnt != '0) begin
         rem <= ge ? sub[N-1:0] : sh[N-1:0];
         low <= {low[N-2:0], 1'b0};
         quo <= {quo[N-2:0], ge};
         cnt <= cnt - ONE_C;
      end
   end

   assign last = (cnt == ONE_C);

   // Partial remainder always stays below the divisor (R1)
   p_rem_below_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (rem < dvs));

   // Iteration count never exceeds the operand width (R7)
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt < $past(cnt)) || $past(load));
endmodule

// File: rtl/idiv_post.sv
// Sign restoration, result formatting and extended-divide fit check
module idiv_post
   import idiv_pkg::*;
#(
   parameter int N = 64
) (
   input  logic [N-1:0] quo,
   input  logic [N-1:0] rem,
   input  logic [1:0]   kind,
   input  logic         sgn,
   input  logic         word,
   input  logic         neg_q,
   input  logic         neg_r,
   output logic [N-1:0] res,
   output logic         late_ov
);
   localparam int W = N / 2;
   localparam logic [N-1:0] ONE_N = N'(1);

   logic [N-1:0] q_s, r_s;
   logic         q_top, q_rest_zero;

   always_comb begin
      q_s = neg_q ? (~quo + ONE_N) : quo;
      r_s = neg_r ? (~rem + ONE_N) : rem;
      q_top       = word ? quo[W-1] : quo[N-1];
      q_rest_zero = word ? (quo[W-2:0] == '0) : (quo[N-2:0] == '0);
      late_ov = (div_kind_e'(kind) == KIND_EXT) & sgn & q_top
                & ~(neg_q & q_rest_zero);
      if (late_ov)
         res = '0;
      else if (div_kind_e'(kind) == KIND_MOD)
         res = word ? (sgn ? {{W{r_s[W-1]}}, r_s[W-1:0]} : {{W{1'b0}}, r_s[W-1:0]})
                    : r_s;
      else
         res = word ? {{W{1'b0}}, q_s[W-1:0]} : q_s;
   end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
   import idiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      kind,
   input  logic            sgn,
   input  logic            word,
   input  logic            oe,
   input  logic            rc,
   input  logic            so_in,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] result,
   output logic            ov,
   output logic            ov32,
   output logic            so_out,
   output logic            flags_we,
   output logic [3:0]      cr0,
   output logic            cr0_we
);
   localparam int W  = XLEN / 2;
   localparam int CW = $clog2(XLEN + 1);

   generate
      if ((XLEN % 2) != 0 || XLEN < 8) begin : g_bad_xlen
         $error("idiv_unit: XLEN must be even and at least 8");
      end
   endgenerate

   div_state_e      state;
   logic [1:0]      l_kind;
   logic            l_sgn, l_word, l_oe, l_rc, l_so, l_neg_q, l_neg_r;
   logic [XLEN-1:0] dvs_mag, rem_init, low_init, quo, rem, post_res;
   logic            neg_q, neg_r, early_ov, core_last, late_ov;
   logic [CW-1:0]   iters;
   logic            take_early, load, fire;

   idiv_prep #(.N(XLEN), .CW(CW)) u_prep (
      .a(opa), .b(opb), .kind(kind), .sgn(sgn), .word(word),
      .dvs_mag(dvs_mag), .rem_init(rem_init), .low_init(low_init),
      .neg_q(neg_q), .neg_r(neg_r), .early_ov(early_ov), .iters(iters)
   );

   idiv_core #(.N(XLEN), .CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load),
      .rem_init(rem_init), .low_init(low_init), .dvs_init(dvs_mag),
      .iters(iters), .quo(quo), .rem(rem), .last(core_last)
   );

   idiv_post #(.N(XLEN)) u_post (
      .quo(quo), .rem(rem), .kind(l_kind), .sgn(l_sgn), .word(l_word),
      .neg_q(l_neg_q), .neg_r(l_neg_r), .res(post_res), .late_ov(late_ov)
   );

   assign take_early = (state == ST_IDLE) & start & early_ov;
   assign load       = (state == ST_IDLE) & start & ~early_ov;
   assign fire       = take_early | (state == ST_FIN);
   assign busy       = (state != ST_IDLE);

   // Completion values, taken from the inputs on the early path
   logic [XLEN-1:0] c_res;
   logic            c_ov, c_mod, c_fwe, c_cwe, c_so;

   always_comb begin
      if (state == ST_FIN) begin
         c_res = post_res;
         c_ov  = late_ov;
         c_mod = (div_kind_e'(l_kind) == KIND_MOD);
         c_fwe = l_oe & ~c_mod;
         c_cwe = l_rc & ~c_mod;
         c_so  = l_so | (c_fwe & c_ov);
      end else begin
         c_res = '0;
         c_ov  = 1'b1;
         c_mod = (div_kind_e'(kind) == KIND_MOD);
         c_fwe = oe & ~c_mod;
         c_cwe = rc & ~c_mod;
         c_so  = so_in | c_fwe;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         l_kind  <= 2'b00;
         l_sgn   <= 1'b0;
         l_word  <= 1'b0;
         l_oe    <= 1'b0;
         l_rc    <= 1'b0;
         l_so    <= 1'b0;
         l_neg_q <= 1'b0;
         l_neg_r <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (load) begin
               state   <= ST_RUN;
               l_kind  <= kind;
               l_sgn   <= sgn;
               l_word  <= word;
               l_oe    <= oe;
               l_rc    <= rc;
               l_so    <= so_in;
               l_neg_q <= neg_q;
               l_neg_r <= neg_r;
            end
            ST_RUN:  if (core_last) state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         result   <= '0;
         ov       <= 1'b0;
         ov32     <= 1'b0;
         so_out   <= 1'b0;
         flags_we <= 1'b0;
         cr0      <= 4'b0000;
         cr0_we   <= 1'b0;
      end else begin
         done <= fire;
         if (fire) begin
            result   <= c_res;
            ov       <= c_ov;
            ov32     <= c_ov;
            so_out   <= c_so;
            flags_we <= c_fwe;
            cr0_we   <= c_cwe;
            cr0      <= {c_res[XLEN-1], ~c_res[XLEN-1] & (c_res != '0),
                         (c_res == '0), c_so};
         end
      end
   end

   // Zero divisor ends at once with overflow and zero result (R3)
   p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (word ? (opb[W-1:0] == '0) : (opb == '0)))
      |=> (done && ov && (result == '0)));

   // Any overflow completion carries a zero result (R6)
   p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ov) |-> (result == '0));

   // Early overflow completes in the next cycle (R7)
   p_early_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_early) |=> (done && ov));

   // Overflow with flag update forces the summary bit (R8)
   p_so_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flags_we && ov) |-> (so_out && ov32));

   // Condition field summary bit mirrors so_out (R9)
   p_cr0_so_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cr0[0] == so_out) && $onehot(cr0[3:1]));

   // Done never overlaps busy (R10)
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // Result held while an operation is still running (R11)
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (done || $stable(result)));
endmodule

// File: tb/idiv_unit_test.sv
`timescale 1ns/1ps
module idiv_unit_test;
   localparam int XL = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    kind = 2'b00;
   logic          sgn = 1'b0, word = 1'b0, oe = 1'b0, rc = 1'b0, so_in = 1'b0;
   logic [XL-1:0] opa = '0, opb = '0;
   logic          busy, done, ov, ov32, so_out, flags_we, cr0_we;
   logic [XL-1:0] result;
   logic [3:0]    cr0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   idiv_unit #(.XLEN(XL)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .sgn(sgn),
      .word(word), .oe(oe), .rc(rc), .so_in(so_in), .opa(opa), .opb(opb),
      .busy(busy), .done(done), .result(result), .ov(ov), .ov32(ov32),
      .so_out(so_out), .flags_we(flags_we), .cr0(cr0), .cr0_we(cr0_we)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      summary();
      $finish;
   end

   // Arithmetic reference from the requirements
   function automatic void model(input logic [1:0] k, input bit s, input bit w,
                                 input logic [7:0] a, input logic [7:0] b,
                                 output logic [7:0] res, output bit ovf,
                                 output bit early);
      int     kb;
      longint m, av, bv, aa, bb, q, r, half;
      kb = w ? 4 : 8;
      m = (longint'(1) << kb) - 1;
      half = longint'(1) << (kb - 1);
      av = longint'(a) & m;
      bv = longint'(b) & m;
      if (s && av >= half) av = av - (m + 1);
      if (s && bv >= half) bv = bv - (m + 1);
      res = '0; ovf = 1'b0; early = 1'b0;
      if (k == 2'b01) begin
         aa = (av < 0) ? -av : av;
         bb = (bv < 0) ? -bv : bv;
         if (aa >= bb) begin
            ovf = 1'b1; early = 1'b1;
         end else begin
            q = (av * (m + 1)) / bv;
            if (s && (q > half - 1 || q < -half)) ovf = 1'b1;
            else res = 8'(q & m);
         end
      end else if (bv == 0 || (s && av == -half && bv == -1)) begin
         ovf = 1'b1; early = 1'b1;
      end else if (k == 2'b10) begin
         r = av % bv;
         res = (w && !s) ? 8'(r & m) : 8'(r & 255);
      end else begin
         q = av / bv;
         res = 8'(q & m);
      end
   endfunction

   function automatic string tag_of(input logic [1:0] k, input bit s, input bit ovf,
                                    input logic [7:0] b, input bit w);
      bit bz;
      bz = w ? (b[3:0] == 4'h0) : (b == 8'h00);
      if (bz) return "R3";
      if (k == 2'b01) return s ? "R6" : "R5";
      if (ovf) return "R4";
      return s ? "R2" : "R1";
   endfunction

   task automatic run_op(input logic [1:0] k, input bit s, input bit w,
                         input logic [7:0] a, input logic [7:0] b,
                         input bit o, input bit r, input bit si);
      logic [7:0] eres;
      bit         eov, eearly, efwe, ecwe, eso, busy_ok;
      logic [3:0] ecr;
      int         lat, elat;
      logic [1:0] mk;
      @(negedge clk);
      kind = k; sgn = s; word = w; opa = a; opb = b; oe = o; rc = r; so_in = si;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      busy_ok = 1'b1;
      while (!done && lat < 40) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      if (busy) busy_ok = 1'b0;
      mk = (k == 2'b11) ? 2'b00 : k;
      model(mk, s, w, a, b, eres, eov, eearly);
      elat = eearly ? 1 : (w ? 6 : 10);
      efwe = o && (mk != 2'b10);
      ecwe = r && (mk != 2'b10);
      eso  = si | (efwe & eov);
      ecr  = {eres[7], !eres[7] && eres != 0, eres == 0, eso};
      checks++;
      if (result !== eres || ov !== eov || lat != elat || !busy_ok) begin
         errors++;
         $display("FAIL %s/R7/R10 k=%0d s=%0d w=%0d a=%h b=%h: actual res=%h ov=%0d lat=%0d busy_ok=%0d expected res=%h ov=%0d lat=%0d",
                  tag_of(mk, s, eov, b, w), k, s, w, a, b, result, ov, lat, busy_ok, eres, eov, elat);
      end
      checks++;
      if (flags_we !== efwe || (efwe && ov32 !== eov) || so_out !== eso ||
          cr0_we !== ecwe || cr0 !== ecr) begin
         errors++;
         $display("FAIL R8/R9 k=%0d a=%h b=%h: actual fwe=%0d ov32=%0d so=%0d cwe=%0d cr0=%b expected fwe=%0d so=%0d cwe=%0d cr0=%b",
                  k, a, b, flags_we, ov32, so_out, cr0_we, cr0, efwe, eso, ecwe, ecr);
      end
   endtask

   logic [7:0] specials [8] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || result !== '0) begin
         errors++;
         $display("FAIL R11 reset: actual busy=%0d done=%0d res=%h expected 0 0 00", busy, done, result);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // Word mode: every 4-bit pair, noisy upper halves (R1-R6)
      for (int kd = 0; kd < 3; kd++)
         for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++)
                  run_op(2'(kd), s[0], 1'b1,
                         8'(((a * 5 + b * 3) & 15) << 4 | a),
                         8'(((a + b * 7) & 15) << 4 | b),
                         a[0] ^ b[1], b[0], a[2]);

      // Full width: strided grid plus edge-value cross (R1-R6)
      for (int kd = 0; kd < 3; kd++)
         for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a += 11)
               for (int b = 0; b < 256; b += 7)
                  run_op(2'(kd), s[0], 1'b0, 8'(a), 8'(b), b[1], a[0], b[3]);
            for (int i = 0; i < 8; i++)
               for (int j = 0; j < 8; j++)
                  run_op(2'(kd), s[0], 1'b0, specials[i], specials[j], 1'b1, 1'b1, j[0]);
         end

      // R2: alternate divide code behaves as plain divide
      run_op(2'b11, 1'b1, 1'b0, 8'hE5, 8'h07, 1'b1, 1'b1, 1'b0);
      run_op(2'b11, 1'b0, 1'b1, 8'h3D, 8'h23, 1'b0, 1'b1, 1'b1);
      run_op(2'b11, 1'b1, 1'b0, 8'h80, 8'hFF, 1'b1, 1'b0, 1'b0);

      // R10: start during an operation is ignored
      @(negedge clk);
      kind = 2'b00; sgn = 1'b0; word = 1'b0; opa = 8'd200; opb = 8'd7;
      oe = 1'b0; rc = 1'b0; so_in = 1'b0; start = 1'b1;
      @(negedge clk);
      opa = 8'd9; opb = 8'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 20 && !done; n++) @(negedge clk);
      checks++;
      if (result !== 8'd28) begin
         errors++;
         $display("FAIL R10 start while busy: actual res=%0d expected 28", result);
      end
      begin
         int extra = 0;
         for (int n = 0; n < 14; n++) begin
            @(negedge clk);
            if (done) extra++;
         end
         checks++;
         if (extra != 0) begin
            errors++;
            $display("FAIL R10 ignored start gave done: actual %0d pulses expected 0", extra);
         end
      end
      // R11: outputs held after completion
      checks++;
      if (result !== 8'd28 || busy !== 1'b0) begin
         errors++;
         $display("FAIL R11 hold: actual res=%0d busy=%0d expected 28 0", result, busy);
      end

      summary();
      $finish;
   end
endmodule